// File: doc/BRIEF.md
# Mode-Switchable Floating-Point Register File

This block stores the floating-point state of a processor that keeps every load, store and integer/float move at 32 bits while still holding 64-bit double-precision values. It has a 32-bit word port that serves transfer traffic. It also has two 64-bit operand read ports and one 64-bit result write port. The result write port has a select that chooses between single and double format.

A single mode input chooses how register indices map onto storage. In the paired layout (mode low), there are thirty-two 32-bit words. Sixteen doubles are formed from an even word and the odd word above it, with the even word holding the low half. In the wide layout (mode high), there are thirty-two independent 64-bit registers, and a word transfer reaches the low half of the named register. Flipping the mode changes only this mapping, never the stored bits, so code written for the paired layout keeps working unchanged.

Reads are combinational and writes land on the rising clock edge. A paired-layout double operand with an odd index is reported on a flag output, and a result write of that kind is dropped.

Top module: `fp_regfile`

## Requirements
- R1: A word-port write of index n lands at the next rising edge. The combinational word read of index n returns the low 32 bits of entry n in both modes.
- R2: In the paired layout, a double read at even index k returns {word k+1, word k}, with word k in bits 31:0.
- R3: In the paired layout, a double operand at an odd index drives illegalOp high. The read data is all zeros, and a double write at that index changes no stored word.
- R4: In the wide layout, a double read or write at any index n, odd or even, reaches the full 64-bit register n.
- R5: In the wide layout, a word-port write to index n leaves the upper 32 bits of register n unchanged.
- R6: A single-format read returns the addressed word in bits 31:0 with bits 63:32 zero. A single-format write changes only the addressed word.
- R7: A read of an index being written in the same cycle returns the value held before the edge.
- R8: When the word write and the result write touch the same word in one cycle, the result write wins. When they touch different words, both land.
- R9: Changing the mode input alters no stored bit. Values written in one layout read back through the other layout's mapping.
- R10: Reset clears every stored bit to zero.
- R11: In the paired layout, a double write at even index k puts bits 31:0 in word k and bits 63:32 in word k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeExt | input | 1 | 1 = wide layout, 0 = paired layout |
| wordWrEn | input | 1 | Word-port write enable |
| wordWrIdx | input | 5 | Word-port write index |
| wordWrData | input | 32 | Word-port write data |
| wordRdIdx | input | 5 | Word-port read index |
| wordRdData | output | 32 | Word-port read data |
| rdIdxA | input | 5 | Operand A index |
| rdDblA | input | 1 | Operand A is double format |
| rdDataA | output | 64 | Operand A data |
| rdIdxB | input | 5 | Operand B index |
| rdDblB | input | 1 | Operand B is double format |
| rdDataB | output | 64 | Operand B data |
| wrEn | input | 1 | Result write enable |
| wrIdx | input | 5 | Result write index |
| wrDbl | input | 1 | Result write is double format |
| wrData | input | 64 | Result write data |
| illegalOp | output | 1 | Odd double operand named in the paired layout |

## Verification
A word-port transfer and a result write can fall in the same cycle and target the same storage. The bench provokes this with a single-format result write to the same index as the word write. It also does it in the paired layout, with the word write aimed at the odd partner of a double write. In both cases the result data must be the value that reads back. A word write to an unrelated index in the same cycle must still land. The bench also holds an operand read on an index while it is being written. It checks that the old value is seen before the edge and the new value after it.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  parameter int unsigned FPR_NUM = 32;
  parameter int unsigned WORD_W  = 32;
  localparam int unsigned IDX_W  = $clog2(FPR_NUM);
  localparam int unsigned DBL_W  = 2 * WORD_W;

  // strobes from control to datapath
  typedef struct packed {
    logic [FPR_NUM-1:0] loArith;  // low word takes result data
    logic [FPR_NUM-1:0] hiArith;  // high word takes result data
    logic [FPR_NUM-1:0] loWord;   // low word takes word-port data
    logic               pairHi;   // paired double: odd word gets upper half
    logic               nullA;    // operand A illegal, drive zero
    logic               nullB;    // operand B illegal, drive zero
  } fprStrobes_t;
endpackage

// File: rtl/fpr_ctrl.sv
module fpr_ctrl
  import fpr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeExt,
  input  logic             wordWrEn,
  input  logic [IDX_W-1:0] wordWrIdx,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic             rdDblA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  logic             rdDblB,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrDbl,
  output fprStrobes_t      strb,
  output logic             illegalOp
);
  logic pairMode;
  logic badWr, badA, badB, wrLegal;
  logic [IDX_W-1:0] wrPartner;

  assign pairMode  = ~modeExt;
  assign badWr     = wrEn & pairMode & wrDbl & wrIdx[0];
  assign badA      = pairMode & rdDblA & rdIdxA[0];
  assign badB      = pairMode & rdDblB & rdIdxB[0];
  assign wrLegal   = wrEn & ~badWr;
  assign wrPartner = {wrIdx[IDX_W-1:1], 1'b1};
  assign illegalOp = badWr | badA | badB;

  always_comb begin
    strb = '0;
    strb.pairHi = pairMode & wrDbl;
    strb.nullA  = badA;
    strb.nullB  = badB;
    for (int j = 0; j < FPR_NUM; j++) begin
      strb.loArith[j] = wrLegal &
                        ((wrIdx == IDX_W'(j)) |
                         (pairMode & wrDbl & (wrPartner == IDX_W'(j))));
      strb.hiArith[j] = wrLegal & modeExt & wrDbl & (wrIdx == IDX_W'(j));
      strb.loWord[j]  = wordWrEn & (wordWrIdx == IDX_W'(j)) & ~strb.loArith[j];
    end
  end

  // R3
  ill_nowr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !modeExt && wrDbl && wrIdx[0]) |-> (strb.loArith == '0 && strb.hiArith == '0));

  // R1
  word_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.loWord));
endmodule

// File: rtl/fpr_dpath.sv
module fpr_dpath
  import fpr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeExt,
  input  fprStrobes_t      strb,
  input  logic [WORD_W-1:0] wordWrData,
  input  logic [DBL_W-1:0]  wrData,
  input  logic [IDX_W-1:0] wordRdIdx,
  output logic [WORD_W-1:0] wordRdData,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic             rdDblA,
  output logic [DBL_W-1:0]  rdDataA,
  input  logic [IDX_W-1:0] rdIdxB,
  input  logic             rdDblB,
  output logic [DBL_W-1:0]  rdDataB
);
  logic [WORD_W-1:0] loMem [FPR_NUM];
  logic [WORD_W-1:0] hiMem [FPR_NUM];

  for (genvar j = 0; j < FPR_NUM; j++) begin : g_entry
    logic [WORD_W-1:0] loArithData;
    assign loArithData = (strb.pairHi && (j % 2 == 1)) ? wrData[DBL_W-1:WORD_W]
                                                        : wrData[WORD_W-1:0];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        loMem[j] <= '0;
        hiMem[j] <= '0;
      end else begin
        if (strb.loArith[j])     loMem[j] <= loArithData;
        else if (strb.loWord[j]) loMem[j] <= wordWrData;
        if (strb.hiArith[j])     hiMem[j] <= wrData[DBL_W-1:WORD_W];
      end
    end

    // R5
    hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !strb.hiArith[j] |=> $stable(hiMem[j]));
  end

  function automatic logic [DBL_W-1:0] readOperand(
    input logic [IDX_W-1:0] idx, input logic dbl, input logic nullOp);
    logic [IDX_W-1:0] partner;
    partner = {idx[IDX_W-1:1], 1'b1};
    if (nullOp)       return '0;
    else if (!dbl)    return {{WORD_W{1'b0}}, loMem[idx]};
    else if (modeExt) return {hiMem[idx], loMem[idx]};
    else              return {loMem[partner], loMem[idx]};
  endfunction

  assign wordRdData = loMem[wordRdIdx];
  assign rdDataA    = readOperand(rdIdxA, rdDblA, strb.nullA);
  assign rdDataB    = readOperand(rdIdxB, rdDblB, strb.nullB);

  // R8
  arb_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loWord & strb.loArith) == '0);

  // R9
  pair_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeExt |-> strb.hiArith == '0);

  // R6
  single_zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdDblA |-> rdDataA[DBL_W-1:WORD_W] == '0) and
    (!rdDblB |-> rdDataB[DBL_W-1:WORD_W] == '0));
endmodule

// File: rtl/fp_regfile.sv
module fp_regfile
  import fpr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeExt,
  input  logic              wordWrEn,
  input  logic [IDX_W-1:0]  wordWrIdx,
  input  logic [WORD_W-1:0] wordWrData,
  input  logic [IDX_W-1:0]  wordRdIdx,
  output logic [WORD_W-1:0] wordRdData,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic              rdDblA,
  output logic [DBL_W-1:0]  rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic              rdDblB,
  output logic [DBL_W-1:0]  rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrDbl,
  input  logic [DBL_W-1:0]  wrData,
  output logic              illegalOp
);
  fprStrobes_t strb;

  fpr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .modeExt(modeExt),
    .wordWrEn(wordWrEn), .wordWrIdx(wordWrIdx),
    .rdIdxA(rdIdxA), .rdDblA(rdDblA), .rdIdxB(rdIdxB), .rdDblB(rdDblB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrDbl(wrDbl),
    .strb(strb), .illegalOp(illegalOp)
  );

  fpr_dpath u_dpath (
    .clk(clk), .rstN(rstN), .modeExt(modeExt), .strb(strb),
    .wordWrData(wordWrData), .wrData(wrData),
    .wordRdIdx(wordRdIdx), .wordRdData(wordRdData),
    .rdIdxA(rdIdxA), .rdDblA(rdDblA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdDblB(rdDblB), .rdDataB(rdDataB)
  );
endmodule

// File: tb/tb_fp_regfile.sv
module tb_fp_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeExt = 1'b0;
  logic        wordWrEn = 1'b0;
  logic [4:0]  wordWrIdx = '0;
  logic [31:0] wordWrData = '0;
  logic [4:0]  wordRdIdx = '0;
  logic [31:0] wordRdData;
  logic [4:0]  rdIdxA = '0;
  logic        rdDblA = 1'b0;
  logic [63:0] rdDataA;
  logic [4:0]  rdIdxB = '0;
  logic        rdDblB = 1'b0;
  logic [63:0] rdDataB;
  logic        wrEn = 1'b0;
  logic [4:0]  wrIdx = '0;
  logic        wrDbl = 1'b0;
  logic [63:0] wrData = '0;
  logic        illegalOp;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mLo [32];
  logic [31:0] mHi [32];

  always #5 clk = ~clk;

  fp_regfile dut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] expRd(input logic [4:0] idx, input logic dbl);
    if (!dbl) return {32'h0, mLo[idx]};
    if (modeExt) return {mHi[idx], mLo[idx]};
    if (idx[0]) return 64'h0;
    return {mLo[idx + 5'd1], mLo[idx]};
  endfunction

  task automatic peek(input string tag, input logic [4:0] idx, input logic dbl);
    rdIdxA = idx; rdDblA = dbl; rdIdxB = idx; rdDblB = dbl; wordRdIdx = idx;
    #1;
    chk({tag, " opA"}, rdDataA, expRd(idx, dbl));
    chk({tag, " opB"}, rdDataB, expRd(idx, dbl));
  endtask

  task automatic peekWord(input string tag, input logic [4:0] idx);
    wordRdIdx = idx; #1;
    chk({tag, " word"}, {32'h0, wordRdData}, {32'h0, mLo[idx]});
  endtask

  // one edge of writes, model updated by word first then result (result wins)
  task automatic step(input logic wwEn, input logic [4:0] wwIdx, input logic [31:0] wwData,
                      input logic aEn, input logic [4:0] aIdx, input logic aDbl,
                      input logic [63:0] aData);
    wordWrEn = wwEn; wordWrIdx = wwIdx; wordWrData = wwData;
    wrEn = aEn; wrIdx = aIdx; wrDbl = aDbl; wrData = aData;
    @(posedge clk);
    if (wwEn) mLo[wwIdx] = wwData;
    if (aEn && !(!modeExt && aDbl && aIdx[0])) begin
      mLo[aIdx] = aData[31:0];
      if (aDbl && modeExt) mHi[aIdx] = aData[63:32];
      if (aDbl && !modeExt) mLo[aIdx + 5'd1] = aData[63:32];
    end
    @(negedge clk);
    wordWrEn = 0; wrEn = 0;
  endtask

  task automatic tReset();
    for (int i = 0; i < 32; i += 7) peekWord("R10 reset", 5'(i));
    modeExt = 1; peek("R10 reset", 5'd3, 1); modeExt = 0;
  endtask

  task automatic tWordPort();
    step(1, 5'd4, 32'h1111_0004, 0, 0, 0, 0);
    step(1, 5'd5, 32'h2222_0005, 0, 0, 0, 0);
    peekWord("R1 w4", 5'd4); peekWord("R1 w5", 5'd5);
    chk("R1 literal", {32'h0, wordRdData}, 64'h2222_0005);
  endtask

  task automatic tPairDbl();
    peek("R2 dbl4", 5'd4, 1);
    chk("R2 literal", rdDataA, 64'h2222_0005_1111_0004);
    step(0, 0, 0, 1, 5'd6, 1, 64'hAAAA_BBBB_CCCC_DDDD);
    peekWord("R11 w6", 5'd6);
    chk("R11 w6 literal", {32'h0, wordRdData}, 64'hCCCC_DDDD);
    peekWord("R11 w7", 5'd7);
    chk("R11 w7 literal", {32'h0, wordRdData}, 64'hAAAA_BBBB);
  endtask

  task automatic tIllegal();
    rdIdxA = 5'd7; rdDblA = 1; rdIdxB = 5'd6; rdDblB = 1; #1;
    chk("R3 flag odd read", {63'h0, illegalOp}, 64'h1);
    chk("R3 zero data", rdDataA, 64'h0);
    rdIdxA = 5'd6; #1;
    chk("R3 flag even", {63'h0, illegalOp}, 64'h0);
    wrEn = 1; wrIdx = 5'd7; wrDbl = 1; wrData = 64'hDEAD_BEEF_0BAD_F00D; #1;
    chk("R3 flag odd write", {63'h0, illegalOp}, 64'h1);
    wrEn = 0;
    step(0, 0, 0, 1, 5'd7, 1, 64'hDEAD_BEEF_0BAD_F00D);
    peekWord("R3 w7 kept", 5'd7); peekWord("R3 w8 kept", 5'd8);
  endtask

  task automatic tWide();
    modeExt = 1;
    step(0, 0, 0, 1, 5'd7, 1, 64'h7777_6666_5555_4444);
    peek("R4 dbl7", 5'd7, 1);
    chk("R4 literal", rdDataA, 64'h7777_6666_5555_4444);
    chk("R4 no flag", {63'h0, illegalOp}, 64'h0);
    step(1, 5'd7, 32'h0101_0101, 0, 0, 0, 0);
    peek("R5 hi kept", 5'd7, 1);
    chk("R5 literal", rdDataA, 64'h7777_6666_0101_0101);
  endtask

  task automatic tSingle();
    step(0, 0, 0, 1, 5'd7, 0, 64'hFFFF_FFFF_1234_5678);
    peek("R6 wide single read", 5'd7, 0);
    peek("R6 wide hi kept", 5'd7, 1);
    modeExt = 0;
    step(0, 0, 0, 1, 5'd8, 0, 64'hEEEE_EEEE_8888_0008);
    peekWord("R6 w9 untouched", 5'd9);
    peek("R6 pair single", 5'd8, 0);
    chk("R6 zext literal", rdDataA, 64'h0000_0000_8888_0008);
  endtask

  task automatic tReadDuringWrite();
    rdIdxA = 5'd4; rdDblA = 1;
    wrEn = 1; wrIdx = 5'd4; wrDbl = 1; wrData = 64'h4444_3333_2222_1111;
    #1;
    chk("R7 old before edge", rdDataA, 64'h2222_0005_1111_0004);
    wrEn = 0;
    step(0, 0, 0, 1, 5'd4, 1, 64'h4444_3333_2222_1111);
    peek("R7 new after edge", 5'd4, 1);
  endtask

  task automatic tCollide();
    step(1, 5'd10, 32'hBAD0_000A, 1, 5'd10, 0, 64'h0000_0000_600D_000A);
    peekWord("R8 same word", 5'd10);
    chk("R8 literal", {32'h0, wordRdData}, 64'h600D_000A);
    step(1, 5'd13, 32'hBAD0_000D, 1, 5'd12, 1, 64'h600D_000D_600D_000C);
    peekWord("R8 partner word", 5'd13);
    step(1, 5'd20, 32'h0000_0020, 1, 5'd21, 0, 64'h21);
    peekWord("R8 both w20", 5'd20); peekWord("R8 both w21", 5'd21);
  endtask

  task automatic tModeSwitch();
    modeExt = 1;
    step(0, 0, 0, 1, 5'd14, 1, 64'h9999_8888_7777_6666);
    step(0, 0, 0, 1, 5'd15, 1, 64'h5555_4444_3333_2222);
    modeExt = 0;
    peek("R9 pair view", 5'd14, 1);
    chk("R9 literal", rdDataA, 64'h3333_2222_7777_6666);
    step(1, 5'd15, 32'hCAFE_0015, 0, 0, 0, 0);
    modeExt = 1;
    peek("R9 wide back 15", 5'd15, 1);
    chk("R9 wide literal", rdDataA, 64'h5555_4444_CAFE_0015);
    peek("R9 wide back 14", 5'd14, 1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin mLo[i] = '0; mHi[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tWordPort();
    tPairDbl();
    tIllegal();
    tWide();
    tSingle();
    tReadDuringWrite();
    tCollide();
    tModeSwitch();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule